// File: doc/BRIEF.md
# Dual-Clock Programmable Level Flags

This block watches the write and read pointers of a dual-clock FIFO and drives two active-low level flags. `afull_n` goes low once the stored word count reaches the depth minus a full-side offset. `aempty_n` goes low once the count has fallen to an empty-side offset or below. Each pointer crosses into the other clock domain as a Gray code through a chain of synchronizer flops. Each domain then works out its own view of the occupancy.

A timing-select input is captured while master reset is held. If it is high, each flag is a plain register in its home domain: the write clock for `afull_n` and the read clock for `aempty_n`. If it is low, each flag is set by an edge of its home clock and released by an edge of the opposite clock. The release happens once that other domain sees that the level condition no longer holds. The offsets are quasi-static inputs supplied by surrounding logic. The FIFO memory and offset loading live outside the block.

Top module: `pflag_gen`

## Requirements
- R1: `timing_sel` is captured only while `mrst` is high (1 = single-domain timing, 0 = split set/release timing); changing it after reset has no effect on flag behaviour.
- R2: While `mrst` is high and just after its release with the FIFO empty, `afull_n` is 1 and `aempty_n` is 0, in either timing mode.
- R3: In steady state, `afull_n` is 0 exactly when occupancy (`wr_ptr - rd_ptr` modulo 2^(AW+1)) is at least 2^AW minus `full_ofs`, and 1 otherwise, in both modes.
- R4: In steady state, `aempty_n` is 0 exactly when occupancy is at most `empty_ofs`, and 1 otherwise, in both modes.
- R5: In single-domain mode, `afull_n` changes only on write-clock edges: with the write clock stopped, reads that free space leave it low.
- R6: In single-domain mode, `aempty_n` changes only on read-clock edges: with the read clock stopped, writes leave it low.
- R7: In both modes, `afull_n` falls on the first write-clock edge at which `wr_ptr` gives an occupancy at or above the full limit, when the read pointer has settled.
- R8: In both modes, `aempty_n` falls on the first read-clock edge at which `rd_ptr` gives an occupancy at or below `empty_ofs`, when the write pointer has settled.
- R9: In split mode, `afull_n` returns high through read-clock edges alone once the read domain sees the occupancy below the full limit, even with the write clock stopped.
- R10: In split mode, `aempty_n` returns high through write-clock edges alone once the write domain sees the occupancy above `empty_ofs`, even with the read clock stopped.
- R11: Pointers cross domains as Gray codes that change by at most one bit per source edge when the pointer advances by at most one, so flags stay correct across pointer wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high, asynchronous assert |
| timing_sel | input | 1 | Flag timing choice, sampled during reset (1 single-domain, 0 split) |
| wr_ptr | input | AW+1 | Binary write pointer, write-clock domain |
| rd_ptr | input | AW+1 | Binary read pointer, read-clock domain |
| full_ofs | input | AW | Full-side offset m |
| empty_ofs | input | AW | Empty-side offset n |
| afull_n | output | 1 | Almost-full flag, active low |
| aempty_n | output | 1 | Almost-empty flag, active low |

## Verification
The bench builds the block with AW = 3, which gives a depth of 8, and two synchronizer stages. At that size every offset value and every occupancy from empty to full can be swept in both timing modes, and the pointers wrap many times along the way. The small depth also makes it cheap to stop one clock entirely. That exposes the difference between the two modes: a flag held by its stalled home domain stays put, while the opposite domain releases it.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

   // Flag timing choice captured at master reset
   typedef enum logic {
      TM_ASYNC = 1'b0,   // set in home domain, released in the other
      TM_SYNC  = 1'b1    // set and released in home domain only
   } tmode_e;

endpackage

// File: rtl/pflag_sync.sv
module pflag_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pflag_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("pflag_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pflag_ptr_xfer.sv
module pflag_ptr_xfer #(
   parameter int PW     = 4,
   parameter int STAGES = 2
) (
   input  logic          src_clk,
   input  logic          dst_clk,
   input  logic          rst,
   input  logic [PW-1:0] src_bin,
   output logic [PW-1:0] dst_bin
);

   logic [PW-1:0] gray_q;
   logic [PW-1:0] gray_s;

   // Registered Gray code in the source domain: only one bit moves per step
   always_ff @(posedge src_clk or posedge rst) begin
      if (rst) gray_q <= '0;
      else     gray_q <= src_bin ^ (src_bin >> 1);
   end

   pflag_sync #(
      .W       (PW),
      .STAGES  (STAGES),
      .RST_VAL ('0)
   ) u_gray_sync (
      .clk (dst_clk),
      .rst (rst),
      .d   (gray_q),
      .q   (gray_s)
   );

   // Gray back to binary: each bit is the parity of itself and all above it
   always_comb begin
      for (int i = 0; i < PW; i++) begin
         dst_bin[i] = ^(gray_s >> i);
      end
   end

   // R11: the crossing word moves by at most one bit per source edge
   p_gray_step_r11: assert property (@(posedge src_clk) disable iff (rst)
      $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/pflag_flag_cell.sv
module pflag_flag_cell
   import pflag_pkg::*;
#(
   parameter int STAGES       = 2,
   parameter bit SET_AT_RESET = 1'b0
) (
   input  logic   set_clk,     // home domain: raises the flag
   input  logic   clr_clk,     // opposite domain: releases it in split mode
   input  logic   rst,
   input  tmode_e mode_set,    // timing choice as held in the home domain
   input  tmode_e mode_clr,    // timing choice as held in the opposite domain
   input  logic   hit_set,     // level condition seen by the home domain
   input  logic   hit_clr,     // level condition seen by the opposite domain
   output logic   flag_n
);

   logic lvl_q;       // single-domain flag state (1 = asserted)
   logic set_tog;     // split mode: flips in home domain to raise
   logic clr_tog;     // split mode: flips in opposite domain to release
   logic clr_tog_s;   // clr_tog as seen by the home domain
   logic set_tog_c;   // set_tog as seen by the opposite domain

   // Single-domain variant: a plain register on the home clock
   always_ff @(posedge set_clk or posedge rst) begin
      if (rst) lvl_q <= SET_AT_RESET;
      else     lvl_q <= hit_set;
   end

   // Split variant, raising side: flip only while flag is seen released
   always_ff @(posedge set_clk or posedge rst) begin
      if (rst)
         set_tog <= SET_AT_RESET;
      else if (mode_set == TM_ASYNC && hit_set && (set_tog == clr_tog_s))
         set_tog <= ~set_tog;
   end

   pflag_sync #(
      .W       (1),
      .STAGES  (STAGES),
      .RST_VAL (1'b0)
   ) u_clr_to_home (
      .clk (set_clk),
      .rst (rst),
      .d   (clr_tog),
      .q   (clr_tog_s)
   );

   pflag_sync #(
      .W       (1),
      .STAGES  (STAGES),
      .RST_VAL (SET_AT_RESET)
   ) u_set_to_other (
      .clk (clr_clk),
      .rst (rst),
      .d   (set_tog),
      .q   (set_tog_c)
   );

   // Split variant, releasing side: flip once the opposite domain sees no hit
   always_ff @(posedge clr_clk or posedge rst) begin
      if (rst)
         clr_tog <= 1'b0;
      else if (mode_clr == TM_ASYNC && !hit_clr && (clr_tog != set_tog_c))
         clr_tog <= ~clr_tog;
   end

   assign flag_n = (mode_set == TM_SYNC) ? ~lvl_q : ~(set_tog ^ clr_tog);

   // R5 / R6: with single-domain timing the opposite domain never releases
   p_sync_hold_r5: assert property (@(posedge clr_clk) disable iff (rst)
      (mode_clr == TM_SYNC) |=> $stable(clr_tog));

   // R7 / R8: a raise in split mode always follows a home-domain hit
   p_set_cause_r7: assert property (@(posedge set_clk) disable iff (rst)
      !$stable(set_tog) |-> $past(hit_set));

   // R9 / R10: a release in split mode always follows an opposite-domain miss
   p_clr_cause_r9: assert property (@(posedge clr_clk) disable iff (rst)
      !$stable(clr_tog) |-> !$past(hit_clr));

endmodule

// File: rtl/pflag_gen.sv
module pflag_gen
   import pflag_pkg::*;
#(
   parameter int AW     = 10,   // log2 of FIFO depth
   parameter int STAGES = 2     // synchronizer flops per crossing
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          mrst,
   input  logic          timing_sel,
   input  logic [AW:0]   wr_ptr,
   input  logic [AW:0]   rd_ptr,
   input  logic [AW-1:0] full_ofs,
   input  logic [AW-1:0] empty_ofs,
   output logic          afull_n,
   output logic          aempty_n
);

   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   generate
      if (AW < 2 || AW > 30) begin : g_bad_aw
         $error("pflag_gen: AW must lie in 2..30");
      end
      if (STAGES < 2) begin : g_bad_stages
         $error("pflag_gen: STAGES must be at least 2");
      end
   endgenerate

   // Timing choice, captured in each domain while reset is held
   tmode_e mode_w, mode_r;

   always_ff @(posedge wclk) begin
      if (mrst) mode_w <= tmode_e'(timing_sel);
   end

   always_ff @(posedge rclk) begin
      if (mrst) mode_r <= tmode_e'(timing_sel);
   end

   // Pointer crossings
   logic [PW-1:0] rptr_w;   // read pointer seen by write domain
   logic [PW-1:0] wptr_r;   // write pointer seen by read domain

   pflag_ptr_xfer #(.PW(PW), .STAGES(STAGES)) u_rd_to_wr (
      .src_clk (rclk),
      .dst_clk (wclk),
      .rst     (mrst),
      .src_bin (rd_ptr),
      .dst_bin (rptr_w)
   );

   pflag_ptr_xfer #(.PW(PW), .STAGES(STAGES)) u_wr_to_rd (
      .src_clk (wclk),
      .dst_clk (rclk),
      .rst     (mrst),
      .src_bin (wr_ptr),
      .dst_bin (wptr_r)
   );

   // Occupancy per domain and level comparisons
   logic [PW-1:0] occ_w, occ_r, full_lim, empty_lim;
   logic          full_hit_w, full_hit_r, empty_hit_w, empty_hit_r;

   assign full_lim    = PW'(DEPTH) - {1'b0, full_ofs};
   assign empty_lim   = {1'b0, empty_ofs};
   assign occ_w       = wr_ptr - rptr_w;
   assign occ_r       = wptr_r - rd_ptr;
   assign full_hit_w  = (occ_w >= full_lim);
   assign full_hit_r  = (occ_r >= full_lim);
   assign empty_hit_w = (occ_w <= empty_lim);
   assign empty_hit_r = (occ_r <= empty_lim);

   // Almost-full: home domain is the write side, starts released
   pflag_flag_cell #(.STAGES(STAGES), .SET_AT_RESET(1'b0)) u_full_flag (
      .set_clk  (wclk),
      .clr_clk  (rclk),
      .rst      (mrst),
      .mode_set (mode_w),
      .mode_clr (mode_r),
      .hit_set  (full_hit_w),
      .hit_clr  (full_hit_r),
      .flag_n   (afull_n)
   );

   // Almost-empty: home domain is the read side, starts asserted
   pflag_flag_cell #(.STAGES(STAGES), .SET_AT_RESET(1'b1)) u_empty_flag (
      .set_clk  (rclk),
      .clr_clk  (wclk),
      .rst      (mrst),
      .mode_set (mode_r),
      .mode_clr (mode_w),
      .hit_set  (empty_hit_r),
      .hit_clr  (empty_hit_w),
      .flag_n   (aempty_n)
   );

endmodule

// File: tb/pflag_gen_test.sv
module pflag_gen_test;

   localparam int AW = 3;
   localparam int PW = AW + 1;
   localparam int D  = 1 << AW;

   logic          wclk = 1'b0;
   logic          rclk = 1'b0;
   logic          mrst = 1'b1;
   logic          timing_sel = 1'b1;
   bit            wrun = 1'b1;
   bit            rrun = 1'b1;
   logic [PW-1:0] wr_ptr = '0;
   logic [PW-1:0] rd_ptr = '0;
   logic [AW-1:0] m_ofs = '0;
   logic [AW-1:0] n_ofs = '0;
   logic          afull_n, aempty_n;

   int occ  = 0;
   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;

   // 250 MHz write clock, slower read clock; either may be stopped low
   always begin #2; if (wrun) wclk = ~wclk; end
   always begin #3; if (rrun) rclk = ~rclk; end

   pflag_gen #(.AW(AW), .STAGES(2)) uut (
      .wclk       (wclk),
      .rclk       (rclk),
      .mrst       (mrst),
      .timing_sel (timing_sel),
      .wr_ptr     (wr_ptr),
      .rd_ptr     (rd_ptr),
      .full_ofs   (m_ofs),
      .empty_ofs  (n_ofs),
      .afull_n    (afull_n),
      .aempty_n   (aempty_n)
   );

   task automatic check(input logic act, input logic exp, input string what);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: got %0b expected %0b (occ=%0d m=%0d n=%0d)",
                  what, act, exp, occ, m_ofs, n_ofs);
      end
   endtask

   function automatic logic paf_model(int o, int m);
      return (o >= D - m) ? 1'b0 : 1'b1;
   endfunction

   function automatic logic pae_model(int o, int n);
      return (o <= n) ? 1'b0 : 1'b1;
   endfunction

   task automatic settle();
      repeat (8) @(negedge rclk);
      repeat (8) @(negedge wclk);
   endtask

   task automatic move_to(input int target);
      while (occ < target) begin
         @(negedge wclk); wr_ptr = wr_ptr + 1'b1; occ++;
      end
      while (occ > target) begin
         @(negedge rclk); rd_ptr = rd_ptr + 1'b1; occ--;
      end
   endtask

   task automatic reset_with(input logic md);
      mrst = 1'b1; timing_sel = md;
      wr_ptr = '0; rd_ptr = '0; occ = 0;
      repeat (4) @(negedge rclk);
      check(afull_n,  1'b1, "R2 afull_n during reset");
      check(aempty_n, 1'b0, "R2 aempty_n during reset");
      @(negedge wclk); mrst = 1'b0;
      settle();
      check(afull_n,  1'b1, "R2 afull_n after reset");
      check(aempty_n, 1'b0, "R2 aempty_n after reset");
   endtask

   initial begin
      #400000;
      if (!done) begin
         nbad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      // Level sweep over every offset and occupancy, both modes (R3, R4)
      for (int md = 1; md >= 0; md--) begin
         reset_with(md[0]);
         for (int m = 0; m < D; m++) begin
            m_ofs = AW'(m);
            n_ofs = AW'((m * 5 + 2) % D);
            settle();
            for (int t = 0; t <= D; t++) begin
               move_to(t); settle();
               check(afull_n,  paf_model(occ, m), "R3 afull level rising");
               check(aempty_n, pae_model(occ, int'(n_ofs)), "R4 aempty level rising");
            end
            for (int t = D - 1; t >= 0; t--) begin
               move_to(t); settle();
               check(afull_n,  paf_model(occ, m), "R3 afull level falling");
               check(aempty_n, pae_model(occ, int'(n_ofs)), "R4 aempty level falling");
            end
         end
         // R11: pointers have wrapped many times by now
         check(afull_n,  1'b1, "R11 afull after pointer wrap");
         check(aempty_n, 1'b0, "R11 aempty after pointer wrap");
      end

      // Assertion latency on the home edge, both modes (R7, R8); R1 flip after reset
      for (int md = 1; md >= 0; md--) begin
         reset_with(md[0]);
         timing_sel = ~md[0];
         m_ofs = 3'd3; n_ofs = 3'd2;
         move_to(4); settle();
         check(afull_n, 1'b1, "R7 afull released below limit");
         @(negedge wclk); wr_ptr = wr_ptr + 1'b1; occ++;
         #1 check(afull_n, 1'b1, "R7 afull before write edge");
         @(posedge wclk); #1;
         check(afull_n, 1'b0, "R7 afull low after first write edge");
         move_to(3); settle();
         check(aempty_n, 1'b1, "R8 aempty released above offset");
         @(negedge rclk); rd_ptr = rd_ptr + 1'b1; occ--;
         #1 check(aempty_n, 1'b1, "R8 aempty before read edge");
         @(posedge rclk); #1;
         check(aempty_n, 1'b0, "R8 aempty low after first read edge");
      end

      // Release with the home clock stopped (R5, R6, R9, R10); R1 flip after reset
      for (int md = 1; md >= 0; md--) begin
         reset_with(md[0]);
         timing_sel = ~md[0];
         m_ofs = 3'd2; n_ofs = 3'd0;
         move_to(7); settle();
         check(afull_n, 1'b0, "R3 afull set before write clock stop");
         @(negedge wclk); wrun = 1'b0;
         repeat (3) begin @(negedge rclk); rd_ptr = rd_ptr + 1'b1; occ--; end
         repeat (8) @(negedge rclk);
         if (md == 1) check(afull_n, 1'b0, "R5 R1 afull held with write clock stopped");
         else         check(afull_n, 1'b1, "R9 R1 afull released by read clock");
         wrun = 1'b1; settle();
         check(afull_n, 1'b1, "R3 afull after write clock restart");

         n_ofs = 3'd2;
         move_to(1); settle();
         check(aempty_n, 1'b0, "R4 aempty set before read clock stop");
         @(negedge rclk); rrun = 1'b0;
         repeat (4) begin @(negedge wclk); wr_ptr = wr_ptr + 1'b1; occ++; end
         repeat (8) @(negedge wclk);
         if (md == 1) check(aempty_n, 1'b0, "R6 R1 aempty held with read clock stopped");
         else         check(aempty_n, 1'b1, "R10 R1 aempty released by write clock");
         rrun = 1'b1; settle();
         check(aempty_n, 1'b1, "R4 aempty after read clock restart");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule